// File: doc/BRIEF.md
# Host Port Slave Interface

This block gives an external host access to on-chip memory through a 16-bit half-word port. The host sees three registers: a control register, an address register and a data register. Every host access is framed by an internal active-low strobe, built from the chip select and two data-strobe inputs. The selects that name the register, the direction and the half-word are captured either by an optional address strobe or at the falling edge of the internal strobe. All inputs are assumed to be already synchronous to `clk`.

A 32-bit word moves as two half-words. Data-register traffic drives a memory-side port that issues one-cycle read or write requests and waits for a one-cycle acknowledge. A data read fetches on its first half-word and holds the host off until the word arrives. A data write, or a read that advances the address, finishes in the background after its second half-word. An active-high busy output tells the host to wait. A one-cycle error pulse reports strobe pulses or gaps that are too short, and strobe releases made while the block is still busy.

Top module: `host_port_slave`

## Requirements
- R1: The internal strobe is active only while `host_cs_n` is 0 and `host_ds_a` differs from `host_ds_b`. When both data strobes are at the same level, or when `host_cs_n` is 1, no register changes.
- R2: When `host_as_n` falls before an access, the select group (`host_sel`, `host_rd`, `host_half`) is taken from that moment. Later changes to the selects during the strobe are ignored. Without an address-strobe fall, the selects are taken at the strobe's falling edge.
- R3: `host_sel` encodes the target as follows: 00 control, 01 address, 10 data with address post-increment, 11 data with a fixed address. `host_half` 0 is the first half-word and 1 is the second. Control bit 0 set to 1 makes the first half the upper 16 bits; 0 makes it the lower 16 bits. Control reads return that bit in bit 0.
- R4: `host_busy` is 0 while `host_cs_n` is 1. If `host_cs_n` falls while a memory operation is pending, `host_busy` is 1 at once and stays 1 until that operation is acknowledged.
- R5: The falling strobe of a first-half data read issues one read request at the address register, unless a prefetched word is already held. `host_busy` stays 1 until the acknowledge loads the data register.
- R6: At the end of a second-half data write, one write request carries the assembled 32-bit word. `host_busy` stays 1 until the acknowledge arrives.
- R7: With select 10, the address register advances by 4 after an acknowledged write. At the end of a second-half read it also advances by 4 and prefetches the word at the new address, so the next first-half read issues no new request. With select 11 the address never changes.
- R8: Accesses to the control or address registers never raise `host_busy`.
- R9: `timing_err` pulses for one cycle in three cases: the strobe is released after fewer than MIN_LOW low samples; it falls again after fewer than MIN_HIGH high samples; or it is released while a memory operation is pending.
- R10: `mem_req` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Chip select, active low |
| host_ds_a | input | 1 | Data strobe A |
| host_ds_b | input | 1 | Data strobe B |
| host_as_n | input | 1 | Optional address strobe, active low (tie high if unused) |
| host_sel | input | 2 | Register select |
| host_rd | input | 1 | 1 = read, 0 = write |
| host_half | input | 1 | Half-word identifier |
| host_wdata | input | HALF_W | Host write data |
| host_rdata | output | HALF_W | Host read data |
| host_busy | output | 1 | Not-ready indication, active high |
| timing_err | output | 1 | Strobe protocol violation pulse |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 2*HALF_W | Memory byte address |
| mem_wdata | output | 2*HALF_W | Memory write word |
| mem_ack | input | 1 | One-cycle acknowledge |
| mem_rdata | input | 2*HALF_W | Memory read word, valid with acknowledge |

## Verification
Some checks hold on every cycle. `mem_req` is a single-cycle pulse. A pending request keeps the selected host busy. An acknowledge clears busy. Control and address traffic leaves busy untouched. Every acknowledged post-increment write moves the address by exactly 4. Other behaviour only the directed scenarios can show: the strobe decode that ignores matching data strobes, selects taken at the address strobe rather than the data strobe, and half-word ordering under both control settings. The scenarios also cover the prefetch that saves a request, busy reappearing when chip select returns during a background write, and each of the three timing-error causes.

// File: rtl/host_port_slave.sv
module host_port_slave #(
  parameter int HALF_W   = 16,
  parameter int MIN_LOW  = 4,
  parameter int MIN_HIGH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs_n,
  input  logic              host_ds_a,
  input  logic              host_ds_b,
  input  logic              host_as_n,
  input  logic [1:0]        host_sel,
  input  logic              host_rd,
  input  logic              host_half,
  input  logic [HALF_W-1:0] host_wdata,
  output logic [HALF_W-1:0] host_rdata,
  output logic              host_busy,
  output logic              timing_err,
  output logic              mem_req,
  output logic              mem_we,
  output logic [2*HALF_W-1:0] mem_addr,
  output logic [2*HALF_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [2*HALF_W-1:0] mem_rdata
);
  localparam int WORD_W  = 2 * HALF_W;
  localparam int CNT_MAX = (MIN_LOW > MIN_HIGH) ? MIN_LOW : MIN_HIGH;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [WORD_W-1:0] STEP = WORD_W'(WORD_W / 8);

  logic stb_n, stb_q, as_q, stb_fall, stb_rise, as_fall;
  logic as_held, as_rd, as_half, rd_q, half_q;
  logic [1:0] as_sel, sel_q;
  logic eff_rd, eff_half;
  logic [1:0] eff_sel;
  logic hi_first, pref_valid, fetch_want, op_active, op_inc, upper, pending;
  logic [WORD_W-1:0] addr_q, data_q, wr_word, addr_word;
  logic [CW-1:0] run_cnt;

  assign stb_n    = ~(host_ds_a ^ host_ds_b) | host_cs_n;
  assign stb_fall = stb_q & ~stb_n;
  assign stb_rise = ~stb_q & stb_n;
  assign as_fall  = as_q & ~host_as_n;

  assign eff_sel  = as_held ? as_sel  : host_sel;
  assign eff_rd   = as_held ? as_rd   : host_rd;
  assign eff_half = as_held ? as_half : host_half;

  assign upper     = half_q ^ hi_first;
  assign wr_word   = upper ? {host_wdata, data_q[HALF_W-1:0]} : {data_q[WORD_W-1:HALF_W], host_wdata};
  assign addr_word = upper ? {host_wdata, addr_q[HALF_W-1:0]} : {addr_q[WORD_W-1:HALF_W], host_wdata};

  assign pending   = op_active | fetch_want;
  assign host_busy = ~host_cs_n & pending;

  always_comb begin
    case (sel_q)
      2'b00:   host_rdata = {{(HALF_W-1){1'b0}}, hi_first};
      2'b01:   host_rdata = upper ? addr_q[WORD_W-1:HALF_W] : addr_q[HALF_W-1:0];
      default: host_rdata = upper ? data_q[WORD_W-1:HALF_W] : data_q[HALF_W-1:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b1;  as_q <= 1'b1;  run_cnt <= CW'(CNT_MAX);
      as_held <= 1'b0; as_sel <= '0; as_rd <= 1'b0; as_half <= 1'b0;
      sel_q <= '0; rd_q <= 1'b0; half_q <= 1'b0;
      hi_first <= 1'b0; pref_valid <= 1'b0; fetch_want <= 1'b0;
      op_active <= 1'b0; op_inc <= 1'b0; timing_err <= 1'b0;
      addr_q <= '0; data_q <= '0;
      mem_req <= 1'b0; mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
    end else begin
      stb_q   <= stb_n;
      as_q    <= host_as_n;
      mem_req <= 1'b0;
      timing_err <= (stb_rise & ((run_cnt < CW'(MIN_LOW)) | pending)) |
                    (stb_fall & (run_cnt < CW'(MIN_HIGH)));
      if (stb_fall | stb_rise) run_cnt <= CW'(1);
      else if (run_cnt != CW'(CNT_MAX)) run_cnt <= run_cnt + CW'(1);

      if (op_active && mem_ack) begin
        op_active <= 1'b0;
        if (!mem_we) begin
          data_q <= mem_rdata;
          pref_valid <= 1'b1;
        end else if (op_inc) addr_q <= addr_q + STEP;
      end

      if (fetch_want && !op_active) begin
        fetch_want <= 1'b0;
        if (!pref_valid) begin
          op_active <= 1'b1; mem_req <= 1'b1; mem_we <= 1'b0;
          mem_addr <= addr_q; op_inc <= 1'b0;
        end
      end

      if (stb_fall) begin
        sel_q <= eff_sel; rd_q <= eff_rd; half_q <= eff_half;
        if (eff_sel[1] && eff_rd && !eff_half && !pref_valid) fetch_want <= 1'b1;
      end

      if (stb_rise) begin
        as_held <= 1'b0;
        if (!rd_q) begin
          pref_valid <= 1'b0;
          case (sel_q)
            2'b00:   hi_first <= host_wdata[0];
            2'b01:   addr_q   <= addr_word;
            default: begin
              data_q <= wr_word;
              if (half_q && !op_active) begin
                op_active <= 1'b1; mem_req <= 1'b1; mem_we <= 1'b1;
                mem_addr <= addr_q; mem_wdata <= wr_word; op_inc <= ~sel_q[0];
              end
            end
          endcase
        end else if (sel_q[1] && half_q) begin
          pref_valid <= 1'b0;
          if (!sel_q[0] && !op_active) begin
            addr_q <= addr_q + STEP;
            op_active <= 1'b1; mem_req <= 1'b1; mem_we <= 1'b0;
            mem_addr <= addr_q + STEP; op_inc <= 1'b0;
          end
        end
      end

      if (as_fall) begin
        as_held <= 1'b1; as_sel <= host_sel; as_rd <= host_rd; as_half <= host_half;
      end
    end
  end

  p_req_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  p_req_holds_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !host_cs_n) |-> host_busy);

  p_ack_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ack && op_active && !fetch_want && !stb_fall && !host_cs_n) |=> !host_busy);

  p_regs_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_rise && !sel_q[1] && !pending) |=> !pending);

  p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ack && op_active && mem_we && op_inc) |=> (addr_q == $past(addr_q) + STEP));
endmodule

// File: tb/host_port_slave_tb.sv
`timescale 1ns/1ps
module host_port_slave_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_cs_n = 1'b1, host_ds_a = 1'b1, host_ds_b = 1'b1, host_as_n = 1'b1;
  logic [1:0] host_sel = 2'b00;
  logic host_rd = 1'b0, host_half = 1'b0;
  logic [15:0] host_wdata = '0, host_rdata;
  logic host_busy, timing_err, mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

  int checks = 0, errors = 0, req_cnt = 0, err_cnt = 0, dbl_req = 0, mem_lat = 2;
  logic last_we;
  logic [31:0] last_addr, last_wd;
  logic [31:0] mem [16];

  always #2.5 clk = ~clk;

  host_port_slave u_dut (
    .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_ds_a(host_ds_a),
    .host_ds_b(host_ds_b), .host_as_n(host_as_n), .host_sel(host_sel),
    .host_rd(host_rd), .host_half(host_half), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_busy(host_busy), .timing_err(timing_err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'hC0DE_0000 | (i * 32'h0000_0111);
    forever begin
      @(posedge clk); #2;
      if (mem_req) begin
        req_cnt++;
        last_we = mem_we; last_addr = mem_addr; last_wd = mem_wdata;
        if (mem_we) mem[mem_addr[5:2]] = mem_wdata;
        repeat (mem_lat) @(posedge clk);
        #2 mem_ack = 1'b1; mem_rdata = mem[last_addr[5:2]];
        @(posedge clk); #2 mem_ack = 1'b0;
      end
    end
  end

  initial begin
    logic prev = 1'b0;
    forever begin
      @(posedge clk); #2;
      if (timing_err) err_cnt++;
      if (mem_req && prev) dbl_req++;
      prev = mem_req;
    end
  end

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic access(input logic [1:0] sel, input logic rd, input logic half,
                        input logic [15:0] wd, output logic [15:0] rdat, output logic busy_seen);
    for (int i = 0; i < 200 && host_busy; i++) tick;
    host_sel = sel; host_rd = rd; host_half = half; host_wdata = wd;
    host_ds_b = 1'b0; busy_seen = 1'b0;
    repeat (4) begin tick; if (host_busy) busy_seen = 1'b1; end
    for (int i = 0; i < 200 && host_busy; i++) begin tick; busy_seen = 1'b1; end
    rdat = host_rdata;
    host_ds_b = 1'b1;
    repeat (4) begin tick; if (host_busy) busy_seen = 1'b1; end
  endtask

  task automatic set_addr(input logic [31:0] a);
    logic [15:0] d; logic b;
    access(2'b01, 1'b0, 1'b0, a[15:0], d, b);
    access(2'b01, 1'b0, 1'b1, a[31:16], d, b);
  endtask

  task automatic t_reset;
    logic [15:0] d; logic b;
    chk("R4 busy after reset", host_busy, 0);
    chk("R10 no request after reset", mem_req, 0);
    chk("R9 no error after reset", timing_err, 0);
    access(2'b00, 1'b1, 1'b0, 16'h0, d, b);
    chk("R3 control resets to 0", d, 0);
  endtask

  task automatic t_regs;
    logic [15:0] d; logic b;
    access(2'b01, 1'b0, 1'b0, 16'h0010, d, b);
    chk("R8 address write leaves busy low", b, 0);
    access(2'b01, 1'b0, 1'b1, 16'h0000, d, b);
    access(2'b01, 1'b1, 1'b0, 16'h0, d, b);
    chk("R3 address first half low", d, 16'h0010);
    chk("R8 address read leaves busy low", b, 0);
    access(2'b00, 1'b0, 1'b0, 16'h0001, d, b);
    chk("R8 control write leaves busy low", b, 0);
    access(2'b01, 1'b1, 1'b0, 16'h0, d, b);
    chk("R3 upper-first order, first half", d, 16'h0000);
    access(2'b01, 1'b1, 1'b1, 16'h0, d, b);
    chk("R3 upper-first order, second half", d, 16'h0010);
    access(2'b00, 1'b1, 1'b0, 16'h0, d, b);
    chk("R3 control readback", d, 16'h0001);
    access(2'b00, 1'b0, 1'b0, 16'h0000, d, b);
  endtask

  task automatic t_read;
    logic [15:0] d; logic b; int r0;
    set_addr(32'h8);
    r0 = req_cnt;
    access(2'b11, 1'b1, 1'b0, 16'h0, d, b);
    chk("R5 first half data", d, mem[2][15:0]);
    chk("R5 busy during fetch", b, 1);
    chk("R5 one request", req_cnt, r0 + 1);
    chk("R5 request is read at address", {last_we, last_addr[30:0]}, 32'h8);
    access(2'b11, 1'b1, 1'b1, 16'h0, d, b);
    chk("R5 second half data", d, mem[2][31:16]);
    chk("R7 fixed read adds no request", req_cnt, r0 + 1);
  endtask

  task automatic t_write;
    logic [15:0] d; logic b; int r0;
    r0 = req_cnt;
    access(2'b11, 1'b0, 1'b0, 16'h1234, d, b);
    chk("R6 no request on first half", req_cnt, r0);
    access(2'b11, 1'b0, 1'b1, 16'hABCD, d, b);
    chk("R6 busy after second half", b, 1);
    chk("R6 one write request", req_cnt, r0 + 1);
    chk("R6 write flag", last_we, 1);
    chk("R6 write address", last_addr, 32'h8);
    chk("R6 assembled word", last_wd, 32'hABCD_1234);
    access(2'b01, 1'b1, 1'b0, 16'h0, d, b);
    chk("R7 fixed write keeps address", d, 16'h0008);
  endtask

  task automatic t_auto;
    logic [15:0] d; logic b; int r0;
    set_addr(32'h20);
    access(2'b10, 1'b0, 1'b0, 16'h5555, d, b);
    access(2'b10, 1'b0, 1'b1, 16'h6666, d, b);
    chk("R7 auto write word", last_wd, 32'h6666_5555);
    chk("R7 auto write address", last_addr, 32'h20);
    access(2'b01, 1'b1, 1'b0, 16'h0, d, b);
    chk("R7 address advanced after write", d, 16'h0024);
    set_addr(32'h30);
    r0 = req_cnt;
    access(2'b10, 1'b1, 1'b0, 16'h0, d, b);
    chk("R5 auto read first half", d, mem[12][15:0]);
    access(2'b10, 1'b1, 1'b1, 16'h0, d, b);
    chk("R7 auto read second half", d, mem[12][31:16]);
    chk("R7 prefetch request issued", req_cnt, r0 + 2);
    chk("R7 prefetch address", last_addr, 32'h34);
    access(2'b01, 1'b1, 1'b0, 16'h0, d, b);
    chk("R7 address advanced after read", d, 16'h0034);
    access(2'b10, 1'b1, 1'b0, 16'h0, d, b);
    chk("R7 prefetched data", d, mem[13][15:0]);
    chk("R7 no request for prefetched word", req_cnt, r0 + 2);
    access(2'b10, 1'b1, 1'b1, 16'h0, d, b);
  endtask

  task automatic t_cs;
    logic [15:0] d; logic b;
    set_addr(32'h10);
    mem_lat = 14;
    access(2'b11, 1'b0, 1'b0, 16'h0001, d, b);
    access(2'b11, 1'b0, 1'b1, 16'h0002, d, b);
    chk("R4 busy while write pending", host_busy, 1);
    host_cs_n = 1'b1; #1;
    chk("R4 busy low with chip select high", host_busy, 0);
    host_cs_n = 1'b0; #1;
    chk("R4 busy at once on chip select", host_busy, 1);
    for (int i = 0; i < 200 && host_busy; i++) tick;
    chk("R4 busy clears after completion", host_busy, 0);
    chk("R6 pending write reached memory", mem[4], 32'h0002_0001);
    mem_lat = 2;
  endtask

  task automatic t_decode;
    logic [15:0] d; logic b; int e0;
    e0 = err_cnt;
    host_sel = 2'b00; host_rd = 1'b0; host_half = 1'b0; host_wdata = 16'h0001;
    host_ds_a = 1'b0; host_ds_b = 1'b0;
    repeat (5) tick;
    host_ds_a = 1'b1; host_ds_b = 1'b1;
    repeat (5) tick;
    host_cs_n = 1'b1; host_ds_b = 1'b0;
    repeat (5) tick;
    host_ds_b = 1'b1; host_cs_n = 1'b0;
    repeat (5) tick;
    access(2'b00, 1'b1, 1'b0, 16'h0, d, b);
    chk("R1 inactive strobe writes nothing", d, 16'h0000);
    chk("R9 no error from correct traffic", err_cnt, e0);
  endtask

  task automatic t_as;
    logic [15:0] d; logic b;
    set_addr(32'h0);
    host_sel = 2'b01; host_rd = 1'b0; host_half = 1'b0; host_as_n = 1'b0;
    tick;
    host_sel = 2'b00; host_half = 1'b1; host_wdata = 16'h0041; host_ds_b = 1'b0;
    repeat (4) tick;
    host_ds_b = 1'b1; host_as_n = 1'b1;
    repeat (4) tick;
    access(2'b00, 1'b1, 1'b0, 16'h0, d, b);
    chk("R2 control untouched", d, 16'h0000);
    access(2'b01, 1'b1, 1'b0, 16'h0, d, b);
    chk("R2 address strobe selects honoured", d, 16'h0041);
  endtask

  task automatic t_err;
    logic [15:0] d; logic b;
    host_sel = 2'b00; host_rd = 1'b1; host_half = 1'b0;
    host_ds_b = 1'b0; repeat (2) tick;
    host_ds_b = 1'b1; tick;
    chk("R9 short low pulse", timing_err, 1);
    repeat (4) tick;
    chk("R9 pulse lasts one cycle", timing_err, 0);
    host_ds_b = 1'b0; repeat (4) tick;
    host_ds_b = 1'b1; tick;
    host_ds_b = 1'b0; tick;
    chk("R9 short high gap", timing_err, 1);
    repeat (3) tick;
    host_ds_b = 1'b1; repeat (4) tick;
    mem_lat = 10;
    set_addr(32'h4);
    host_sel = 2'b11; host_rd = 1'b1; host_half = 1'b0;
    host_ds_b = 1'b0; repeat (4) tick;
    host_ds_b = 1'b1; tick;
    chk("R9 release while busy", timing_err, 1);
    for (int i = 0; i < 200 && host_busy; i++) tick;
    repeat (4) tick;
    mem_lat = 2;
    access(2'b00, 1'b1, 1'b0, 16'h0, d, b);
    chk("R9 clean access after errors", timing_err, 0);
  endtask

  initial begin
    repeat (3) tick;
    rst_n = 1'b1;
    tick;
    host_cs_n = 1'b0;
    repeat (6) tick;
    t_reset;
    t_regs;
    t_read;
    t_write;
    t_auto;
    t_cs;
    t_decode;
    t_as;
    t_err;
    chk("R10 request never two cycles", dbl_req, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule